// File: doc/BRIEF.md
# Frequent-Pattern Word Compressor

This block takes a 64-byte memory block as a stream of sixteen 32-bit words and turns it into a compact, variable-length bitstream. Each word is matched against a small set of common value shapes: small sign-extended integers, a halfword sitting in the upper half, two sign-extended bytes, one byte repeated four times. The word is then replaced by a 3-bit prefix naming the shape and only the bits needed to rebuild it. Consecutive zero words are not coded one by one. They are merged into a single run code of at most eight words.

Words arrive with a valid strobe, one per cycle at most, and idle cycles are allowed between them. After the sixteenth accepted word the block raises a one-cycle done pulse. At that point the packed stream and its length in whole bytes are stable, and a downstream size classifier reads them. The result stays on the outputs until the first word of the next block arrives. That word starts a fresh, empty stream.

Top module: `fpc_block_packer`

## Requirements
- R1: Codes are packed least-significant-bit first, back to back from stream bit 0. Each code holds its 3-bit prefix in its lowest bits, with the payload directly above the prefix.
- R2: A word that matches no other shape is coded as prefix 111 followed by all 32 bits of the word (35 bits).
- R3: Zero words form runs coded as prefix 000 with a 3-bit payload equal to the run length minus one (6 bits). A run never exceeds eight words: a ninth consecutive zero word starts a new run.
- R4: A word that sign-extends from its low 4, 8 or 16 bits is coded as prefix 001, 010 or 011 respectively, with only those low bits as payload.
- R5: A word whose low halfword is zero is coded as prefix 100 with its upper halfword as the 16-bit payload.
- R6: A word whose two halfwords are each a sign-extended byte is coded as prefix 101. Its payload is {byte 2, byte 0}, with byte 2 in the upper 8 payload bits.
- R7: A word made of one byte repeated four times is coded as prefix 110 with that byte as the 8-bit payload.
- R8: When several shapes match, the shortest code wins: zero first, then 4-bit sign-extension, then 8-bit sign-extension, then repeated byte, then 16-bit sign-extension, then padded halfword, then byte pair, and the raw form last.
- R9: A pending zero run is emitted when a non-zero word follows it, or at the end of the block when the final word is zero.
- R10: Once the sixteenth word is accepted, done is high for exactly one cycle. In that same cycle the byte count equals the total code bits rounded up to a multiple of 8.
- R11: Cycles with valid low change nothing. Every sixteen accepted words close a block, and the next block starts from an empty stream with all stream bits above its own codes at zero.
- R12: After reset, done is low, the byte count is 0 and the stream is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is presented this cycle |
| in_word | input | 32 | Word to compress |
| out_stream | output | 560 | Packed code stream, LSB first |
| out_bytes | output | 7 | Compressed length in bytes |
| out_done | output | 1 | One-cycle pulse when a block is complete |

## Verification
The hardest situations to reach from the ports are those where a zero run interacts with the run cap and the block end in the same cycle as another code. Examples are an eight-word run closing just as a ninth zero arrives, or a capped run and a leftover run both being emitted on the final word. The stimulus reaches these by placing zeros deliberately. It uses an all-zero block, which emits two full runs with the second one flushed by the block end. It uses nine leading zeros, which split into runs of eight and one. It also uses one raw word followed by fifteen zeros, which leaves runs of eight and seven with the seven closed only by the end of the block. Tie-breaking words such as all-ones and repeated 0x80 bytes confirm that the priority order is followed.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int WORD_W = 32;
    localparam int PFX_W  = 3;
    localparam int CODE_W = PFX_W + WORD_W;
    localparam int LEN_W  = $clog2(CODE_W + 1);

    typedef enum logic [PFX_W-1:0] {
        PFX_ZRUN     = 3'b000,
        PFX_SE4      = 3'b001,
        PFX_SE8      = 3'b010,
        PFX_SE16     = 3'b011,
        PFX_PADHW    = 3'b100,
        PFX_BYTEPAIR = 3'b101,
        PFX_REPB     = 3'b110,
        PFX_RAW      = 3'b111
    } pfx_e;

    typedef struct packed {
        logic [CODE_W-1:0] bits;
        logic [LEN_W-1:0]  len;
    } code_t;
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify
    import fpc_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic              zero_o,
    output code_t             code_o
);
    logic se4, se8, se16, padhw, pair, repb;

    always_comb begin
        se4   = (word_i[31:3]  == {29{word_i[3]}});
        se8   = (word_i[31:7]  == {25{word_i[7]}});
        se16  = (word_i[31:15] == {17{word_i[15]}});
        padhw = (word_i[15:0]  == 16'h0000);
        pair  = (word_i[31:23] == {9{word_i[23]}}) && (word_i[15:7] == {9{word_i[7]}});
        repb  = (word_i[31:24] == word_i[23:16]) && (word_i[23:16] == word_i[15:8])
             && (word_i[15:8] == word_i[7:0]);
        zero_o = (word_i == '0);

        code_o.bits = '0;
        code_o.len  = '0;
        if (zero_o) begin
            code_o.bits[PFX_W-1:0] = PFX_ZRUN;
        end else if (se4) begin
            code_o.bits[PFX_W-1:0] = PFX_SE4;
            code_o.bits[PFX_W+:4]  = word_i[3:0];
            code_o.len             = LEN_W'(PFX_W + 4);
        end else if (se8) begin
            code_o.bits[PFX_W-1:0] = PFX_SE8;
            code_o.bits[PFX_W+:8]  = word_i[7:0];
            code_o.len             = LEN_W'(PFX_W + 8);
        end else if (repb) begin
            code_o.bits[PFX_W-1:0] = PFX_REPB;
            code_o.bits[PFX_W+:8]  = word_i[7:0];
            code_o.len             = LEN_W'(PFX_W + 8);
        end else if (se16) begin
            code_o.bits[PFX_W-1:0] = PFX_SE16;
            code_o.bits[PFX_W+:16] = word_i[15:0];
            code_o.len             = LEN_W'(PFX_W + 16);
        end else if (padhw) begin
            code_o.bits[PFX_W-1:0] = PFX_PADHW;
            code_o.bits[PFX_W+:16] = word_i[31:16];
            code_o.len             = LEN_W'(PFX_W + 16);
        end else if (pair) begin
            code_o.bits[PFX_W-1:0] = PFX_BYTEPAIR;
            code_o.bits[PFX_W+:16] = {word_i[23:16], word_i[7:0]};
            code_o.len             = LEN_W'(PFX_W + 16);
        end else begin
            code_o.bits[PFX_W-1:0] = PFX_RAW;
            code_o.bits[PFX_W+:32] = word_i;
            code_o.len             = LEN_W'(CODE_W);
        end
    end
endmodule

// File: rtl/fpc_bit_append.sv
module fpc_bit_append
    import fpc_pkg::*;
#(
    parameter int STREAM_W = 560,
    parameter int POS_W    = 10
) (
    input  logic [STREAM_W-1:0] stream_i,
    input  logic [POS_W-1:0]    pos_i,
    input  logic                en_i,
    input  code_t               code_i,
    output logic [STREAM_W-1:0] stream_o,
    output logic [POS_W-1:0]    pos_o
);
    logic [STREAM_W-1:0] placed;

    always_comb begin
        placed = STREAM_W'(code_i.bits) << pos_i;
        if (en_i) begin
            stream_o = stream_i | placed;
            pos_o    = pos_i + POS_W'(code_i.len);
        end else begin
            stream_o = stream_i;
            pos_o    = pos_i;
        end
    end
endmodule

// File: rtl/fpc_block_packer.sv
module fpc_block_packer
    import fpc_pkg::*;
#(
    parameter int BLOCK_WORDS = 16,
    parameter int RUN_MAX     = 8
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            in_valid,
    input  logic [31:0]                                     in_word,
    output logic [BLOCK_WORDS*(fpc_pkg::CODE_W)-1:0]        out_stream,
    output logic [$clog2(BLOCK_WORDS*(fpc_pkg::CODE_W)/8+1)-1:0] out_bytes,
    output logic                                            out_done
);
    localparam int STREAM_W = BLOCK_WORDS * CODE_W;
    localparam int POS_W    = $clog2(STREAM_W + 8);
    localparam int BYTE_W   = $clog2(STREAM_W / 8 + 1);
    localparam int RUN_W    = $clog2(RUN_MAX + 1);
    localparam int RUNF_W   = $clog2(RUN_MAX);
    localparam int IDX_W    = $clog2(BLOCK_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_WORDS - 1);

    typedef struct packed {
        logic [STREAM_W-1:0] stream;
        logic [POS_W-1:0]    pos;
        logic [RUN_W-1:0]    run;
        logic [IDX_W-1:0]    idx;
        logic                done;
    } st_t;

    st_t st_d, st_q;

    function automatic code_t run_code(input logic [RUN_W-1:0] n);
        code_t c;
        c.bits = '0;
        c.bits[PFX_W-1:0]      = PFX_ZRUN;
        c.bits[PFX_W+:RUNF_W]  = RUNF_W'(n - 1'b1);
        c.len                  = LEN_W'(PFX_W + RUNF_W);
        return c;
    endfunction

    // word classification
    logic  w_zero;
    code_t w_code;

    fpc_classify u_cls (
        .word_i (in_word),
        .zero_o (w_zero),
        .code_o (w_code)
    );

    // emission selection
    logic [STREAM_W-1:0] base_stream, mid_stream, end_stream;
    logic [POS_W-1:0]    base_pos, mid_pos, end_pos;
    logic [RUN_W-1:0]    base_run, run_mid, run_next;
    logic                last_word, emit_a, emit_b;
    code_t               code_a, code_b;

    always_comb begin
        if (st_q.idx == '0) begin
            base_stream = '0;
            base_pos    = '0;
            base_run    = '0;
        end else begin
            base_stream = st_q.stream;
            base_pos    = st_q.pos;
            base_run    = st_q.run;
        end
        last_word = (st_q.idx == LAST_IDX);
        emit_a    = 1'b0;
        emit_b    = 1'b0;
        code_a    = run_code(base_run);
        code_b    = w_code;
        run_mid   = base_run;
        run_next  = base_run;
        if (w_zero) begin
            if (base_run == RUN_W'(RUN_MAX)) begin
                emit_a  = 1'b1;
                run_mid = RUN_W'(1);
            end else begin
                run_mid = base_run + 1'b1;
            end
            if (last_word) begin
                emit_b   = 1'b1;
                code_b   = run_code(run_mid);
                run_next = '0;
            end else begin
                run_next = run_mid;
            end
        end else begin
            emit_a   = (base_run != '0);
            emit_b   = 1'b1;
            run_next = '0;
        end
    end

    fpc_bit_append #(.STREAM_W(STREAM_W), .POS_W(POS_W)) u_app_a (
        .stream_i (base_stream),
        .pos_i    (base_pos),
        .en_i     (emit_a),
        .code_i   (code_a),
        .stream_o (mid_stream),
        .pos_o    (mid_pos)
    );

    fpc_bit_append #(.STREAM_W(STREAM_W), .POS_W(POS_W)) u_app_b (
        .stream_i (mid_stream),
        .pos_i    (mid_pos),
        .en_i     (emit_b),
        .code_i   (code_b),
        .stream_o (end_stream),
        .pos_o    (end_pos)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (in_valid) begin
            st_d.stream = end_stream;
            st_d.pos    = end_pos;
            st_d.run    = run_next;
            st_d.idx    = last_word ? '0 : st_q.idx + 1'b1;
            st_d.done   = last_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_stream = st_q.stream;
    assign out_bytes  = BYTE_W'((st_q.pos + POS_W'(7)) >> 3);
    assign out_done   = st_q.done;

    // R3: pending run never passes the cap
    a_r3_run_cap: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run <= RUN_W'(RUN_MAX));

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R10: the last word of a block raises done next cycle
    a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && st_q.idx == LAST_IDX) |=> st_q.done);

    // R10: bit count never exceeds the stream
    a_r10_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos <= POS_W'(STREAM_W));

    // R11: idle cycles leave length and index untouched and raise no done
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(st_q.pos) && $stable(st_q.idx) && !st_q.done));

    // R1: within a block the bit count never shrinks
    a_r1_pos_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && st_q.idx != '0) |=> st_q.pos >= $past(st_q.pos));

    // R8: a non-zero word always gets one of the legal code lengths
    a_r8_code_len: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !w_zero) |-> (w_code.len == LEN_W'(7) || w_code.len == LEN_W'(11)
                                  || w_code.len == LEN_W'(19) || w_code.len == LEN_W'(35)));
endmodule

// File: tb/sim_fpc_block_packer.sv
`timescale 1ns/1ps
module sim_fpc_block_packer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_word = '0;
    logic [559:0] out_stream;
    logic [6:0]   out_bytes;
    logic         out_done;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    fpc_block_packer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .out_stream (out_stream),
        .out_bytes  (out_bytes),
        .out_done   (out_done)
    );

    typedef struct packed {
        logic [31:0] fill;
        logic [1:0]  mode;   // 0 all fill, 1 zero/fill alternating, 2 nine zeros then fill, 3 fill then zeros
        logic [6:0]  bytes;
        logic [34:0] code;
        logic [5:0]  clen;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h12345678, 2'd0, 7'd70, {32'h12345678, 3'b111}, 6'd35}, // R2
        '{32'h00000005, 2'd0, 7'd14, 35'h29,    6'd7},               // R4
        '{32'hFFFFFFFF, 2'd0, 7'd14, 35'h79,    6'd7},               // R8
        '{32'hFFFFFF80, 2'd0, 7'd22, 35'h402,   6'd11},              // R4
        '{32'h5A5A5A5A, 2'd0, 7'd22, 35'h2D6,   6'd11},              // R7
        '{32'h80808080, 2'd0, 7'd22, 35'h406,   6'd11},              // R8
        '{32'h00001234, 2'd0, 7'd38, 35'h091A3, 6'd19},              // R4
        '{32'hFFFF8000, 2'd0, 7'd38, 35'h40003, 6'd19},              // R8
        '{32'hABCD0000, 2'd0, 7'd38, 35'h55E6C, 6'd19},              // R5
        '{32'h007FFF80, 2'd0, 7'd38, 35'h3FC05, 6'd19},              // R6
        '{32'h12345678, 2'd1, 7'd41, {32'h12345678, 3'b111}, 6'd35}, // R9
        '{32'h00000003, 2'd2, 7'd8,  35'h19,    6'd7},               // R3
        '{32'h12345678, 2'd3, 7'd6,  {32'h12345678, 3'b111}, 6'd35}, // R9
        '{32'h00000080, 2'd0, 7'd38, 35'h403,   6'd19}               // R8
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] put(input logic [35:0] h, input int pos, input logic [34:0] code);
        logic [127:0] t;
        t = {93'b0, code} << pos;
        return h | t[35:0];
    endfunction

    function automatic logic [31:0] word_of(input logic [31:0] fill, input logic [1:0] mode, input int i);
        case (mode)
            2'd0:    return fill;
            2'd1:    return (i % 2 == 1) ? fill : 32'h0;
            2'd2:    return (i < 9) ? 32'h0 : fill;
            default: return (i == 0) ? fill : 32'h0;
        endcase
    endfunction

    function automatic logic [35:0] head_of(input vec_t v);
        logic [35:0] h = '0;
        case (v.mode)
            2'd0: for (int p = 0; p < 36; p += int'(v.clen)) h = put(h, p, v.code);
            2'd1: for (int p = 0; p < 36; p += 6 + int'(v.clen)) h = put(h, p + 6, v.code);
            2'd2: begin
                h = put(h, 0, 35'h38);
                for (int p = 12; p < 36; p += int'(v.clen)) h = put(h, p, v.code);
            end
            default: begin
                h = put(h, 0, v.code);
                h = put(h, int'(v.clen), 35'h38);
                h = put(h, int'(v.clen) + 6, 35'h30);
            end
        endcase
        return h;
    endfunction

    // drives one block; returns at the negedge after the last word was captured
    task automatic feed(input logic [31:0] fill, input logic [1:0] mode, input bit gaps);
        for (int i = 0; i < 16; i++) begin
            in_valid = 1'b1;
            in_word  = word_of(fill, mode, i);
            @(negedge clk);
            if (gaps && i < 15) begin
                in_valid = 1'b0;
                in_word  = 32'hDEADBEEF;
                @(negedge clk);
                chk(out_done == 1'b0, "R11 idle no done", 64'(out_done), 64'd0);
            end
        end
        in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(out_done == 1'b0, "R12 done", 64'(out_done), 64'd0);
        chk(out_bytes == 7'd0, "R12 bytes", 64'(out_bytes), 64'd0);
        chk(out_stream == '0, "R12 stream", 64'(out_stream[63:0]), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1, R2, R4..R10
        for (int k = 0; k < NV; k++) begin
            feed(VECS[k].fill, VECS[k].mode, 1'b0);
            chk(out_done == 1'b1, "R10 done", 64'(out_done), 64'd1);
            chk(out_bytes == VECS[k].bytes, "R10 bytes", 64'(out_bytes), 64'(VECS[k].bytes));
            chk(out_stream[35:0] == head_of(VECS[k]), "R1 stream head",
                64'(out_stream[35:0]), 64'(head_of(VECS[k])));
            @(negedge clk);
            chk(out_done == 1'b0, "R10 pulse width", 64'(out_done), 64'd0);
            chk(out_bytes == VECS[k].bytes, "R10 bytes held", 64'(out_bytes), 64'(VECS[k].bytes));
        end

        // R3: all-zero block gives two capped runs, second closed at block end
        feed(32'h0, 2'd0, 1'b0);
        chk(out_bytes == 7'd2, "R3 zero block bytes", 64'(out_bytes), 64'd2);
        chk(out_stream[35:0] == 36'hE38, "R3 zero block stream", 64'(out_stream[35:0]), 64'hE38);
        @(negedge clk);

        // R11: idle gaps between words, fresh block after a long one
        feed(32'h12345678, 2'd0, 1'b0);
        @(negedge clk);
        feed(32'h00000005, 2'd0, 1'b1);
        chk(out_done == 1'b1, "R11 gapped done", 64'(out_done), 64'd1);
        chk(out_bytes == 7'd14, "R11 gapped bytes", 64'(out_bytes), 64'd14);
        chk(out_stream[559:112] == '0, "R11 fresh stream upper", 64'(out_stream[175:112]), 64'd0);
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule